// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Clock Generator

This block turns a fast oscillator clock into the pair of processor clock phases that a small microprocessor system needs. A 2-bit counter divides the oscillator by four. Each phase is high for one oscillator cycle in every four. Between the two phases sits one oscillator cycle of dead time in which neither phase is high. The second phase is also driven out as a buffered copy for the rest of the system. The undivided oscillator is forwarded unchanged for display timing.

A power-on reset input produces a reset output for the processor system. The reset output goes low at once when power-on reset is asserted. It is released only after a programmable number of oscillator cycles, synchronised to the oscillator. Once power-on reset is released, the phases start running at once. They keep toggling while the reset output is still held low, so the processor can initialise itself during that window.

Top module: `two_phase_clkgen`

## Requirements
- R1: `ph1` and `ph2` are never high in the same oscillator cycle.
- R2: Each phase is high for exactly one oscillator cycle in every four, with a period of four oscillator cycles.
- R3: `ph2` is high two oscillator cycles after `ph1` is high, and one dead cycle with both phases low lies between them in each direction.
- R4: `ph2_buf` carries the same value as `ph2` in every cycle.
- R5: `disp_clk` follows `osc_clk` at the oscillator frequency, with no division.
- R6: While `por_n` is low, `rst_n_out`, `ph1` and `ph2` are all low. `rst_n_out` falls as soon as `por_n` falls, without waiting for an oscillator edge.
- R7: After `por_n` rises, `rst_n_out` rises on rising edge number RST_CYCLES+3 of `osc_clk`, counting edges from the release. It then stays high until `por_n` falls again.
- R8: The phases start right after `por_n` is released, while `rst_n_out` is still low. `ph2` is high after edge 2, `ph1` is high after edge 4, and the pattern then repeats every four edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Fast oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ph1 | output | 1 | Processor clock phase 1 |
| ph2 | output | 1 | Processor clock phase 2 |
| ph2_buf | output | 1 | Buffered phase 2 for system use |
| disp_clk | output | 1 | Undivided oscillator for display timing |
| rst_n_out | output | 1 | System reset, active low, released synchronously |

## Verification
The bench follows every oscillator cycle through two power-up sequences. It predicts each phase from the number of edges since release. A counter that starts one count off would move the first `ph1` and `ph2` edges, and a decode that overlaps or leaves out the dead cycles would drive both phases high together or let them drift. The release of `rst_n_out` is checked on its exact edge, so a missing synchroniser stage or a count that is off by one shows up. Power-on reset is also pulled low partway through a cycle, which catches a design that asserts reset synchronously and so lets `rst_n_out` linger until the next edge.

// File: rtl/two_phase_clkgen.sv
module two_phase_clkgen #(
  parameter int RST_CYCLES = 16
) (
  input  logic osc_clk,
  input  logic por_n,
  output logic ph1,
  output logic ph2,
  output logic ph2_buf,
  output logic disp_clk,
  output logic rst_n_out
);

  localparam int CW = (RST_CYCLES < 1) ? 1 : $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] HOLD = CW'(RST_CYCLES);

  logic [1:0]    div_q;
  logic          ph1_q, ph2_q;
  logic          sync1_q, sync2_q;
  logic [CW-1:0] hold_q;
  logic          rel_q;

  always_ff @(posedge osc_clk or negedge por_n) begin
    if (!por_n) begin
      div_q <= 2'd0;
      ph1_q <= 1'b0;
      ph2_q <= 1'b0;
    end else begin
      div_q <= div_q + 2'd1;
      ph1_q <= (div_q == 2'd3);
      ph2_q <= (div_q == 2'd1);
    end
  end

  always_ff @(posedge osc_clk or negedge por_n) begin
    if (!por_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      hold_q  <= '0;
      rel_q   <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
      if (sync2_q && hold_q != HOLD) hold_q <= hold_q + 1'b1;
      rel_q <= sync2_q && (hold_q == HOLD);
    end
  end

  assign ph1       = ph1_q;
  assign ph2       = ph2_q;
  assign ph2_buf   = ph2_q;
  assign disp_clk  = osc_clk;
  assign rst_n_out = rel_q;

endmodule

module two_phase_clkgen_chk (
  input logic osc_clk,
  input logic por_n,
  input logic ph1,
  input logic ph2,
  input logic rst_n_out
);

  p_no_overlap_r1: assert property (@(posedge osc_clk) disable iff (!por_n)
    !(ph1 && ph2));

  p_ph1_one_cycle_r2: assert property (@(posedge osc_clk) disable iff (!por_n)
    ph1 |=> !ph1);

  p_ph1_period_r2: assert property (@(posedge osc_clk) disable iff (!por_n)
    ph1 |-> ##4 ph1);

  p_dead_after_ph1_r3: assert property (@(posedge osc_clk) disable iff (!por_n)
    ph1 |=> (!ph1 && !ph2));

  p_ph2_follows_r3: assert property (@(posedge osc_clk) disable iff (!por_n)
    ph1 |-> ##2 ph2);

  p_rst_holds_r7: assert property (@(posedge osc_clk) disable iff (!por_n)
    rst_n_out |=> rst_n_out);

  always @(negedge osc_clk)
    if (por_n === 1'b0)
      p_por_forces_r6: assert (!rst_n_out && !ph1 && !ph2);

endmodule

bind two_phase_clkgen two_phase_clkgen_chk u_chk (
  .osc_clk(osc_clk), .por_n(por_n), .ph1(ph1), .ph2(ph2), .rst_n_out(rst_n_out)
);

// File: tb/two_phase_clkgen_test.sv
module two_phase_clkgen_test;

  localparam int N = 16;

  logic osc_clk = 1'b0;
  logic por_n = 1'b0;
  logic ph1, ph2, ph2_buf, disp_clk, rst_n_out;
  int   errors = 0;
  int   checks = 0;
  bit   done = 0;

  always #5 osc_clk = ~osc_clk;

  two_phase_clkgen #(.RST_CYCLES(N)) uut (
    .osc_clk(osc_clk), .por_n(por_n), .ph1(ph1), .ph2(ph2),
    .ph2_buf(ph2_buf), .disp_clk(disp_clk), .rst_n_out(rst_n_out)
  );

  task automatic chk(input string req, input logic act, input logic exp, input int k);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s edge=%0d actual=%b expected=%b", req, k, act, exp);
    end
  endtask

  task automatic sweep(input int edges);
    for (int k = 1; k <= edges; k++) begin
      @(posedge osc_clk);
      #1;
      chk("R5 disp_clk high", disp_clk, 1'b1, k);
      #1;
      chk("R2 R8 ph1", ph1, (k % 4 == 0), k);
      chk("R3 R8 ph2", ph2, (k % 4 == 2), k);
      chk("R1 overlap", ph1 & ph2, 1'b0, k);
      chk("R4 ph2_buf", ph2_buf, ph2, k);
      chk("R7 rst_n_out", rst_n_out, (k >= N + 3), k);
      #4;
      chk("R5 disp_clk low", disp_clk, 1'b0, k);
    end
  endtask

  initial begin
    #3;
    chk("R6 reset rst", rst_n_out, 1'b0, 0);
    chk("R6 reset ph1", ph1, 1'b0, 0);
    chk("R6 reset ph2", ph2, 1'b0, 0);
    @(negedge osc_clk);
    @(negedge osc_clk);
    por_n = 1'b1;
    sweep(N + 12);
    @(posedge osc_clk);
    #2;
    por_n = 1'b0;
    #1;
    chk("R6 async rst", rst_n_out, 1'b0, 0);
    chk("R6 async ph1", ph1, 1'b0, 0);
    chk("R6 async ph2", ph2, 1'b0, 0);
    repeat (3) @(posedge osc_clk);
    #2;
    chk("R6 held rst", rst_n_out, 1'b0, 0);
    chk("R6 held ph", ph1 | ph2, 1'b0, 0);
    @(negedge osc_clk);
    por_n = 1'b1;
    sweep(N + 9);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule